// File: doc/BRIEF.md
# Center-Aligned Three-Phase PWM with Quiet-Window ADC Trigger

This block drives the high-side gate commands of a three-phase bridge from a single up/down counter. All three phases share that counter, so they stay locked in phase. Each pulse is symmetric about the bottom of the count, and pulses with different duties sit inside one another. Once per period it also raises a one-cycle ADC start pulse. The pulse is placed so that a fixed-length current sample straddles the middle of the span in which all three phase outputs are low. Switching edges therefore never fall inside the sample.

Every duty word is limited to a ceiling that keeps a minimum common off span open near the top of the count. A run-time limit input can lower that ceiling further but can never raise it. New duties take effect only when the counter turns at the top, where every output is already low. A kill input gates all three outputs low in the same cycle it is asserted. At the default sizing with a 32 MHz clock, the period is 2048 clocks (64 us), the off span is at least 64 clocks (2 us), and the trigger leads the window center by 27 clocks.

Top module: `pwm_center3`

## Requirements
- R1: While rst_ni is low and in the cycle after its release, ph_o is 3'b000 and adc_start_o is 0. The counter starts at 0, counting up.
- R2: The counter visits 0..CNT_MAX up, then CNT_MAX..0 down, with each end value held for two cycles. adc_start_o pulses for one cycle every 2*(CNT_MAX+1) = 2048 clocks.
- R3: Phase p (bit p of ph_o, duty word duty_i[p*11 +: 11]) is high while the counter is strictly below its latched compare value C. Its pulse lasts exactly 2*C clocks per period.
- R4: Each pulse is centered on the bottom of the count. Counting from the clock after the trigger, phase p rises at 1051-C and falls at 1051+C. Phases with different duties therefore nest about a common center.
- R5: A duty word of 0 keeps its phase low for the whole period.
- R6: The latched compare value never exceeds DUTY_CEIL = CNT_MAX+1-OFF_HALF (992 by default). A larger duty word gives a 1984-clock pulse, so all three outputs share an off span of at least 2*OFF_HALF = 64 clocks.
- R7: The compare value is min(duty, max_duty_i, DUTY_CEIL). A max_duty_i below the ceiling shortens pulses; one above it has no effect.
- R8: adc_start_o rises only while all phases are low. It occurs TRIG_LEAD = 27 clocks before the top turnaround, on the up count at counter value CNT_MAX+1-TRIG_LEAD (997), which is 997 clocks after reset release.
- R9: Duty words are latched only in the first top cycle (counter at CNT_MAX, counting up). A change in mid-period leaves the current pulse unchanged and applies from the next period.
- R10: While kill_i is high, ph_o is 3'b000 in the same cycle. When kill_i is released, the outputs follow the compare again without disturbing the timebase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| duty_i | input | 33 | Three 11-bit duty words; phase p in bits p*11 +: 11 |
| max_duty_i | input | 11 | Run-time duty limit, bounded by DUTY_CEIL |
| kill_i | input | 1 | Forces all phase outputs low while high |
| ph_o | output | 3 | Phase high-side commands |
| adc_start_o | output | 1 | One-cycle ADC start pulse |

## Verification
The bench measures the rise and fall offsets of each phase against the trigger. An off-by-one in the compare sense, or a counter that does not hold its end values, would shift these edges or break the 2*C width. Duties of 0, the ceiling and above the ceiling catch a missing or misplaced clamp, which would either close the common off window or let a zero duty emit a sliver of pulse. A duty change in mid-pulse catches latching at the wrong turnaround, which would produce an asymmetric pulse. Kill is applied in mid-pulse and released again to expose a registered or sticky gate.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} cnt_dir_e;
endpackage

// File: rtl/pwm3_timebase.sv
module pwm3_timebase
  import pwm3_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int TRIG_LEAD = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             load_o,
  output logic             trig_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] TRIG_CNT = CNT_W'((1 << CNT_W) - TRIG_LEAD);

  logic [CNT_W-1:0] cnt_q;
  cnt_dir_e         dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (dir_q == DIR_UP) begin
      if (cnt_q == CNT_MAX) dir_q <= DIR_DN;  // hold end value one extra cycle
      else                  cnt_q <= cnt_q + 1'b1;
    end else begin
      if (cnt_q == '0) dir_q <= DIR_UP;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign load_o = (dir_q == DIR_UP) && (cnt_q == CNT_MAX);
  assign trig_o = (dir_q == DIR_UP) && (cnt_q == TRIG_CNT);
endmodule

// File: rtl/pwm3_duty_clamp.sv
module pwm3_duty_clamp #(
  parameter int DUTY_W    = 11,
  parameter int DUTY_CEIL = 992
) (
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [DUTY_W-1:0] limit_i,
  output logic [DUTY_W-1:0] duty_o
);
  localparam logic [DUTY_W-1:0] CEIL = DUTY_W'(DUTY_CEIL);
  logic [DUTY_W-1:0] lim;

  always_comb begin
    lim    = (limit_i < CEIL) ? limit_i : CEIL;
    duty_o = (duty_i < lim) ? duty_i : lim;
  end
endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase #(
  parameter int CNT_W  = 10,
  parameter int DUTY_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              kill_i,
  output logic [DUTY_W-1:0] cmp_o,
  output logic              ph_o
);
  logic [DUTY_W-1:0] cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmp_q <= '0;
    else if (load_i) cmp_q <= duty_i;
  end

  assign cmp_o = cmp_q;
  assign ph_o  = ({1'b0, cnt_i} < cmp_q) && !kill_i;
endmodule

// File: rtl/pwm_center3.sv
module pwm_center3 #(
  parameter int CNT_W     = 10,
  parameter int OFF_HALF  = 32,
  parameter int TRIG_LEAD = 27,
  parameter int N_PH      = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_PH*(CNT_W+1)-1:0]  duty_i,
  input  logic [CNT_W:0]             max_duty_i,
  input  logic                       kill_i,
  output logic [N_PH-1:0]            ph_o,
  output logic                       adc_start_o
);
  localparam int DUTY_W    = CNT_W + 1;
  localparam int DUTY_CEIL = (1 << CNT_W) - OFF_HALF;

  logic [CNT_W-1:0]             cnt;
  logic                         load;
  logic [N_PH-1:0][DUTY_W-1:0]  duty_clamped;
  logic [N_PH-1:0][DUTY_W-1:0]  cmp;

  pwm3_timebase #(.CNT_W(CNT_W), .TRIG_LEAD(TRIG_LEAD)) u_tb (
    .clk_i, .rst_ni, .cnt_o(cnt), .load_o(load), .trig_o(adc_start_o)
  );

  for (genvar p = 0; p < N_PH; p++) begin : g_ph
    pwm3_duty_clamp #(.DUTY_W(DUTY_W), .DUTY_CEIL(DUTY_CEIL)) u_clamp (
      .duty_i (duty_i[p*DUTY_W +: DUTY_W]),
      .limit_i(max_duty_i),
      .duty_o (duty_clamped[p])
    );
    pwm3_phase #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_phase (
      .clk_i, .rst_ni,
      .load_i(load),
      .duty_i(duty_clamped[p]),
      .cnt_i (cnt),
      .kill_i,
      .cmp_o (cmp[p]),
      .ph_o  (ph_o[p])
    );
  end
endmodule

// File: rtl/pwm_center3_chk.sv
module pwm_center3_chk #(
  parameter int CNT_W    = 10,
  parameter int OFF_HALF = 32,
  parameter int N_PH     = 3
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          kill_i,
  input logic [N_PH-1:0]               ph_o,
  input logic                          adc_start_o,
  input logic [CNT_W-1:0]              cnt_i,
  input logic                          load_i,
  input logic [N_PH-1:0][CNT_W:0]      cmp_i
);
  localparam int CEIL = (1 << CNT_W) - OFF_HALF;
  int unsigned cur, prv;
  assign cur = int'(cnt_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prv <= 0; else prv <= cur;

  AST_TRIG_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> ph_o == '0) else $error("trigger during switching"); // R8
  AST_TRIG_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |=> !adc_start_o) else $error("trigger too long"); // R2
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur == prv) || (cur == prv + 1) || (cur + 1 == prv)) else $error("counter jump"); // R2
  AST_KILL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |-> ph_o == '0) else $error("kill ignored"); // R10
  AST_CMP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) |-> $stable(cmp_i)) else $error("compare changed off turnaround"); // R9

  for (genvar p = 0; p < N_PH; p++) begin : g_c
    AST_CMP_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(cmp_i[p]) <= CEIL) else $error("compare above ceiling"); // R6
  end
endmodule

bind pwm_center3 pwm_center3_chk #(.CNT_W(CNT_W), .OFF_HALF(OFF_HALF), .N_PH(N_PH)) u_chk (
  .clk_i, .rst_ni, .kill_i, .ph_o, .adc_start_o,
  .cnt_i(cnt), .load_i(load), .cmp_i(cmp)
);

// File: tb/pwm_center3_bench.sv
`timescale 1ns/1ps
module pwm_center3_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [32:0] duty_i = '0;
  logic [10:0] max_duty_i = 11'd1024;
  logic        kill_i = 1'b0;
  logic [2:0]  ph_o;
  logic        adc_start_o;

  int n_run = 0, n_fail = 0;
  int rise_k[3], fall_k[3];
  bit trig_quiet;

  always #4 clk_i = ~clk_i;

  pwm_center3 u_pwm_center3 (.*);

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_duty(int a, int b, int c);
    duty_i = {11'(c), 11'(b), 11'(a)};
  endtask

  task automatic wait_trig();
    do @(negedge clk_i); while (!adc_start_o);
  endtask

  // edges counted in clocks after the trigger
  task automatic measure();
    wait_trig();
    trig_quiet = (ph_o == 3'b000);
    for (int p = 0; p < 3; p++) begin rise_k[p] = -1; fall_k[p] = -1; end
    for (int k = 1; k < 2048; k++) begin
      @(negedge clk_i);
      for (int p = 0; p < 3; p++) begin
        if (ph_o[p] && rise_k[p] < 0) rise_k[p] = k;
        if (!ph_o[p] && rise_k[p] >= 0 && fall_k[p] < 0) fall_k[p] = k;
      end
    end
  endtask

  task automatic expect_pulse(int p, int c, string req);
    if (c == 0) check(rise_k[p] == -1, req, rise_k[p], -1);
    else begin
      check(rise_k[p] == 1051 - c, req, rise_k[p], 1051 - c);
      check(fall_k[p] == 1051 + c, req, fall_k[p], 1051 + c);
    end
  endtask

  task automatic t_reset();
    int k;
    check(ph_o == 3'b000 && !adc_start_o, "R1", int'(ph_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check(ph_o == 3'b000 && !adc_start_o, "R1", int'(adc_start_o), 0);
    k = 1;
    while (!adc_start_o && k < 3000) begin @(negedge clk_i); k++; end
    check(k == 997, "R8", k, 997);
  endtask

  task automatic t_period();
    int k = 0;
    wait_trig();
    do begin @(negedge clk_i); k++; end while (!adc_start_o);
    check(k == 2048, "R2", k, 2048);
  endtask

  task automatic t_nested();
    set_duty(256, 512, 768);
    measure();
    expect_pulse(0, 256, "R3");
    expect_pulse(1, 512, "R4");
    expect_pulse(2, 768, "R4");
    check(fall_k[0] - rise_k[0] == 512, "R3", fall_k[0] - rise_k[0], 512);
    check(trig_quiet, "R8", int'(trig_quiet), 1);
  endtask

  task automatic t_edges();
    set_duty(0, 1, 992);
    measure();
    expect_pulse(0, 0, "R5");
    expect_pulse(1, 1, "R3");
    expect_pulse(2, 992, "R6");
    set_duty(1024, 1000, 993);
    measure();
    for (int p = 0; p < 3; p++) expect_pulse(p, 992, "R6");
    check(trig_quiet, "R8", int'(trig_quiet), 1);
  endtask

  task automatic t_limit();
    max_duty_i = 11'd300;
    set_duty(800, 300, 100);
    measure();
    expect_pulse(0, 300, "R7");
    expect_pulse(1, 300, "R7");
    expect_pulse(2, 100, "R7");
    max_duty_i = 11'd2047;
    set_duty(1024, 0, 0);
    measure();
    expect_pulse(0, 992, "R7");
    max_duty_i = 11'd1024;
  endtask

  task automatic t_midchange();
    int f = -1;
    set_duty(500, 500, 500);
    wait_trig(); wait_trig();
    for (int k = 1; k < 2048; k++) begin
      @(negedge clk_i);
      if (k == 600) set_duty(100, 100, 100);
      if (k > 600 && !ph_o[0] && f < 0) f = k;
    end
    check(f == 1551, "R9", f, 1551);
    measure();
    expect_pulse(0, 100, "R9");
  endtask

  task automatic t_kill();
    set_duty(600, 600, 600);
    wait_trig(); wait_trig();
    repeat (1051) @(negedge clk_i);
    check(ph_o == 3'b111, "R10", int'(ph_o), 7);
    kill_i = 1'b1; #1;
    check(ph_o == 3'b000, "R10", int'(ph_o), 0);
    repeat (20) @(negedge clk_i);
    check(ph_o == 3'b000, "R10", int'(ph_o), 0);
    kill_i = 1'b0; #1;
    check(ph_o == 3'b111, "R10", int'(ph_o), 7);
    measure();
    expect_pulse(1, 600, "R10");
  endtask

  initial begin
    t_reset();
    t_period();
    t_nested();
    t_edges();
    t_limit();
    t_midchange();
    t_kill();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule